// File: doc/BRIEF.md
# Four-Channel PWM Control Register File

This block is the control front end of a multi-channel pulse-width modulator. It sits behind a simple memory-mapped read/write port and holds everything a driver programs: which channels run, the per-channel prescale and output inversion, and the active and queued duty and period values. The waveform generators themselves are outside the block. Each generator reports the start of a new period on a one-cycle `period_start` pulse, and the block turns that pulse into three things: a latched event bit, the moment at which queued duty or period values take effect, and the moment at which a requested stop completes.

Starting and stopping use two separate write-one registers, so software never has to read-modify-write a shared enable word. A stop request does not take effect at once. The channel keeps running, and keeps reporting itself as running, until its current period ends. Software can therefore poll the status word to learn when the output is really idle. The event register gathers period starts from all channels and clears entirely when it is read.

Top module: `pwm_regfile`

## Requirements
- R1: After synchronous reset, `ch_run`, `ch_start`, the status word, the event word, every channel's mode, active and queued duty and period values, and `rdata` are all zero.
- R2: A write to offset 0x04 sets `ch_run[n]` on the next clock for every data bit n that is 1. Bits that are 0 leave their channels unchanged.
- R3: A write to offset 0x08 records a stop request for every running channel n whose data bit is 1. `ch_run[n]` and status bit n stay at 1 while the request is outstanding. Bits that are 0 have no effect.
- R4: A channel with an outstanding stop request clears `ch_run[n]` on the clock edge that samples `period_start[n]` high. Before that edge the bit stays set. A write to offset 0x04 with bit n set cancels the outstanding stop request for channel n.
- R5: A read of offset 0x0C returns `ch_run` in bits [NCH-1:0], and all higher bits read as zero.
- R6: Each `period_start[n]` pulse sets bit n of the event word. A read of offset 0x1C returns the whole event word and clears all of its bits.
- R7: A `period_start` pulse that arrives in the same cycle as a read of offset 0x1C is not part of that read's data. Its bit stays latched and appears in the next read.
- R8: Channel n's registers sit at 0x200 + n×0x20. The mode register is at window offset 0x00: bits [3:0] hold the prescale value (`ch_prescale`) and bit 9 holds output inversion (`ch_invert`). Its other bits read as zero, so a read-modify-write of one field keeps the other field.
- R9: A write to window offset 0x04 (duty) or 0x0C (period) updates the channel's `ch_duty` or `ch_period` output on the next clock. Both fields are DW bits wide and read back zero-extended.
- R10: A write to window offset 0x08 (queued duty) or 0x10 (queued period) stores a value that reads back at once but leaves `ch_duty` or `ch_period` unchanged. The value is copied to the active output on the edge that samples that channel's `period_start` high.
- R11: Reads return data in `rdata` one clock after `rd_en`, and `rdata` is zero in any cycle that follows no read. Reads of unmapped offsets return zero. Unmapped offsets include global offsets other than the four listed above, window offsets other than the five listed above, and addresses beyond the last channel. Writes to unmapped offsets change nothing.
- R12: `ch_start[n]` pulses high for exactly one clock after an enable write that starts channel n while it was stopped. An enable write to an already running channel produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | AW | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one clock after `rd_en` |
| period_start | input | NCH | Per-channel one-cycle period-start pulse from the generators |
| ch_run | output | NCH | Per-channel run control, also the status word |
| ch_start | output | NCH | One-cycle pulse when a stopped channel is started |
| ch_prescale | output | NCH×4 | Per-channel prescale value, channel n in bits [4n+3:4n] |
| ch_invert | output | NCH | Per-channel output inversion |
| ch_duty | output | NCH×DW | Active duty value per channel |
| ch_period | output | NCH×DW | Active period value per channel |

## Verification
A wrong run or stop-request state shows at `ch_run` on the clock after the enable write or the period-start pulse that should have changed it. It shows on the status read one clock later. A wrongly latched or wrongly cleared event bit hides until the next event-word read, so the bench reads the event word right after every group of pulses and again right after each read. A queued duty or period value that is applied early or lost shows on `ch_duty` or `ch_period` before or after that channel's next period-start pulse. The bench therefore checks the outputs on both sides of the pulse.

// File: rtl/pwm_regfile_pkg.sv
package pwm_regfile_pkg;

  // global register offsets (byte addresses)
  localparam int unsigned GOFS_START  = 32'h004;
  localparam int unsigned GOFS_STOP   = 32'h008;
  localparam int unsigned GOFS_STATUS = 32'h00C;
  localparam int unsigned GOFS_EVENT  = 32'h01C;

  // channel window geometry
  localparam int unsigned WIN_BASE    = 32'h200;
  localparam int unsigned WIN_SHIFT   = 5;
  localparam int unsigned WIN_STRIDE  = 32'h1 << WIN_SHIFT;

  // offsets inside one channel window
  localparam int unsigned WOFS_MODE     = 32'h00;
  localparam int unsigned WOFS_DUTY     = 32'h04;
  localparam int unsigned WOFS_DUTY_NXT = 32'h08;
  localparam int unsigned WOFS_PER      = 32'h0C;
  localparam int unsigned WOFS_PER_NXT  = 32'h10;

  // mode register fields
  localparam int unsigned PRE_W   = 4;
  localparam int unsigned INV_BIT = 9;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_MODE,
    RK_DUTY,
    RK_DUTY_NXT,
    RK_PER,
    RK_PER_NXT
  } reg_kind_e;

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_regfile_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NCH = 4,
  parameter int CIW = 2
) (
  input  logic [AW-1:0]  addr,
  output logic           sel_start,
  output logic           sel_stop,
  output logic           sel_status,
  output logic           sel_event,
  output logic           win_hit,
  output logic [CIW-1:0] win_idx,
  output reg_kind_e      win_kind
);

  localparam int unsigned WIN_END = WIN_BASE + NCH * WIN_STRIDE;

  logic [31:0] a32;
  logic [31:0] rel;
  logic [31:0] wofs;

  assign a32  = 32'(addr);
  assign rel  = a32 - WIN_BASE;
  assign wofs = rel & (WIN_STRIDE - 1);

  always_comb begin
    sel_start  = 1'b0;
    sel_stop   = 1'b0;
    sel_status = 1'b0;
    sel_event  = 1'b0;
    win_hit    = 1'b0;
    win_idx    = '0;
    win_kind   = RK_NONE;
    if (a32 < WIN_BASE) begin
      sel_start  = (a32 == GOFS_START);
      sel_stop   = (a32 == GOFS_STOP);
      sel_status = (a32 == GOFS_STATUS);
      sel_event  = (a32 == GOFS_EVENT);
    end else if (a32 < WIN_END) begin
      win_idx = CIW'(rel >> WIN_SHIFT);
      case (wofs)
        WOFS_MODE:     win_kind = RK_MODE;
        WOFS_DUTY:     win_kind = RK_DUTY;
        WOFS_DUTY_NXT: win_kind = RK_DUTY_NXT;
        WOFS_PER:      win_kind = RK_PER;
        WOFS_PER_NXT:  win_kind = RK_PER_NXT;
        default:       win_kind = RK_NONE;
      endcase
      win_hit = (win_kind != RK_NONE);
    end
  end

endmodule

// File: rtl/pwm_run_ctl.sv
module pwm_run_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_wr,
  input  logic           stop_wr,
  input  logic [NCH-1:0] wmask,
  input  logic [NCH-1:0] tick,
  input  logic           event_rd,
  output logic [NCH-1:0] run,
  output logic [NCH-1:0] start_pulse,
  output logic [NCH-1:0] event_bits
);

  logic [NCH-1:0] stop_req;
  logic [NCH-1:0] set_mask;
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] stop_now;

  assign set_mask = start_wr ? wmask : '0;
  assign clr_mask = stop_wr  ? wmask : '0;
  assign stop_now = stop_req & tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      run         <= '0;
      stop_req    <= '0;
      start_pulse <= '0;
      event_bits  <= '0;
    end else begin
      run         <= (run & ~stop_now) | set_mask;
      stop_req    <= ((stop_req & ~tick) | (clr_mask & run)) & ~set_mask;
      start_pulse <= set_mask & ~run;
      event_bits  <= (event_rd ? '0 : event_bits) | tick;
    end
  end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_regfile_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  reg_kind_e        kind,
  input  logic [31:0]      wdata,
  input  logic             tick,
  output logic [PRE_W-1:0] prescale,
  output logic             invert,
  output logic [DW-1:0]    duty,
  output logic [DW-1:0]    period,
  output logic [31:0]      rd_word
);

  logic [DW-1:0] duty_nxt;
  logic [DW-1:0] per_nxt;
  logic          duty_pend;
  logic          per_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescale  <= '0;
      invert    <= 1'b0;
      duty      <= '0;
      period    <= '0;
      duty_nxt  <= '0;
      per_nxt   <= '0;
      duty_pend <= 1'b0;
      per_pend  <= 1'b0;
    end else begin
      if (tick && duty_pend) begin
        duty      <= duty_nxt;
        duty_pend <= 1'b0;
      end
      if (tick && per_pend) begin
        period   <= per_nxt;
        per_pend <= 1'b0;
      end
      if (wr) begin
        case (kind)
          RK_MODE: begin
            prescale <= wdata[PRE_W-1:0];
            invert   <= wdata[INV_BIT];
          end
          RK_DUTY:     duty   <= wdata[DW-1:0];
          RK_PER:      period <= wdata[DW-1:0];
          RK_DUTY_NXT: begin
            duty_nxt  <= wdata[DW-1:0];
            duty_pend <= 1'b1;
          end
          RK_PER_NXT: begin
            per_nxt  <= wdata[DW-1:0];
            per_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (kind)
      RK_MODE: begin
        rd_word[PRE_W-1:0] = prescale;
        rd_word[INV_BIT]   = invert;
      end
      RK_DUTY:     rd_word = 32'(duty);
      RK_DUTY_NXT: rd_word = 32'(duty_nxt);
      RK_PER:      rd_word = 32'(period);
      RK_PER_NXT:  rd_word = 32'(per_nxt);
      default:     rd_word = '0;
    endcase
  end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_regfile_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NCH-1:0]       period_start,
  output logic [NCH-1:0]       ch_run,
  output logic [NCH-1:0]       ch_start,
  output logic [NCH*PRE_W-1:0] ch_prescale,
  output logic [NCH-1:0]       ch_invert,
  output logic [NCH*DW-1:0]    ch_duty,
  output logic [NCH*DW-1:0]    ch_period
);

  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           sel_start, sel_stop, sel_status, sel_event;
  logic           win_hit;
  logic [CIW-1:0] win_idx;
  reg_kind_e      win_kind;
  logic [NCH-1:0] event_bits;
  logic [31:0]    ch_word [NCH];
  logic [31:0]    rd_mux;

  pwm_addr_decode #(.AW(AW), .NCH(NCH), .CIW(CIW)) u_dec (
    .addr       (addr),
    .sel_start  (sel_start),
    .sel_stop   (sel_stop),
    .sel_status (sel_status),
    .sel_event  (sel_event),
    .win_hit    (win_hit),
    .win_idx    (win_idx),
    .win_kind   (win_kind)
  );

  pwm_run_ctl #(.NCH(NCH)) u_run (
    .clk         (clk),
    .rst         (rst),
    .start_wr    (wr_en && sel_start),
    .stop_wr     (wr_en && sel_stop),
    .wmask       (wdata[NCH-1:0]),
    .tick        (period_start),
    .event_rd    (rd_en && sel_event),
    .run         (ch_run),
    .start_pulse (ch_start),
    .event_bits  (event_bits)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan_regs #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_en && win_hit && (win_idx == CIW'(g))),
      .kind     (win_kind),
      .wdata    (wdata),
      .tick     (period_start[g]),
      .prescale (ch_prescale[g*PRE_W +: PRE_W]),
      .invert   (ch_invert[g]),
      .duty     (ch_duty[g*DW +: DW]),
      .period   (ch_period[g*DW +: DW]),
      .rd_word  (ch_word[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (sel_status)   rd_mux = 32'(ch_run);
    else if (sel_event) rd_mux = 32'(event_bits);
    else if (win_hit) rd_mux = ch_word[win_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_mux : '0;
  end

endmodule

// File: rtl/pwm_regfile_chk.sv
module pwm_regfile_chk #(
  parameter int AW  = 10,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           rd_en,
  input logic [AW-1:0]  addr,
  input logic [31:0]    wdata,
  input logic [31:0]    rdata,
  input logic [NCH-1:0] period_start,
  input logic [NCH-1:0] ch_run,
  input logic [NCH-1:0] ch_start
);

  localparam logic [AW-1:0] A_START  = AW'(32'h004);
  localparam logic [AW-1:0] A_STOP   = AW'(32'h008);
  localparam logic [AW-1:0] A_EVENT  = AW'(32'h01C);
  localparam logic [AW-1:0] A_HOLE   = AW'(32'h010);

  AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_START) |=>
      ((ch_run & $past(wdata[NCH-1:0])) == $past(wdata[NCH-1:0]))); // R2

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STOP) |=>
      (($past(ch_run & ~period_start) & ~ch_run) == '0)); // R3

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~ch_run & $past(ch_run) & ~$past(period_start)) == '0)); // R4

  AST_EVENT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_EVENT && period_start == '0) ##1
    (rd_en && addr == A_EVENT && period_start == '0) |=> (rdata == '0)); // R6

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_HOLE) |=> (rdata == '0)); // R11

  AST_START_ONLY_NEW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ch_start & $past(ch_run)) == '0)); // R12

endmodule

bind pwm_regfile pwm_regfile_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .period_start (period_start),
  .ch_run       (ch_run),
  .ch_start     (ch_start)
);

// File: tb/pwm_regfile_tb.sv
module pwm_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH-1:0]    period_start = '0;
  logic [NCH-1:0]    ch_run;
  logic [NCH-1:0]    ch_start;
  logic [NCH*4-1:0]  ch_prescale;
  logic [NCH-1:0]    ch_invert;
  logic [NCH*DW-1:0] ch_duty;
  logic [NCH*DW-1:0] ch_period;

  int errors = 0;
  int checks = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_regfile #(.AW(AW), .NCH(NCH), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .period_start(period_start),
    .ch_run(ch_run), .ch_start(ch_start), .ch_prescale(ch_prescale),
    .ch_invert(ch_invert), .ch_duty(ch_duty), .ch_period(ch_period)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read data appears one clock after the read strobe
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check("R11 unexpected read data", 64'(rdata), 64'hDEAD);
      else check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp,
                          input string tag, input logic [NCH-1:0] ev);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a; period_start = ev;
    @(negedge clk);
    rd_en = 1'b0; addr = '0; period_start = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    period_start = m;
    @(negedge clk);
    period_start = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ch_run", 64'(ch_run), 64'h0);
    check("R1 duty", 64'(ch_duty), 64'h0);
    check("R1 rdata", 64'(rdata), 64'h0);
    bus_read(10'h00C, 32'h0, "R1 status", '0);
    bus_read(10'h01C, 32'h0, "R1 event", '0);
    bus_read(10'h248, 32'h0, "R1 queued duty", '0);

    // R2 / R12 start
    bus_write(10'h004, 32'h5);
    check("R2 run after start", 64'(ch_run), 64'h5);
    check("R12 start pulse", 64'(ch_start), 64'h5);
    bus_write(10'h004, 32'h3);
    check("R2 zero bits keep", 64'(ch_run), 64'h7);
    check("R12 no pulse on running", 64'(ch_start), 64'h2);
    @(negedge clk);
    check("R12 pulse one clock", 64'(ch_start), 64'h0);
    bus_read(10'h00C, 32'h7, "R5 status", '0);

    // R3 / R4 stop at end of period
    bus_write(10'h008, 32'h1);
    check("R3 run held", 64'(ch_run), 64'h7);
    bus_read(10'h00C, 32'h7, "R3 status held", '0);
    pulse(4'h2);
    check("R4 other tick no stop", 64'(ch_run), 64'h7);
    pulse(4'h1);
    check("R4 stop on tick", 64'(ch_run), 64'h6);
    bus_read(10'h00C, 32'h6, "R4 status cleared", '0);
    bus_read(10'h01C, 32'h3, "R6 event latched", '0);
    bus_read(10'h01C, 32'h0, "R6 event cleared", '0);
    bus_write(10'h008, 32'h0);
    check("R3 zero bits ignored", 64'(ch_run), 64'h6);
    bus_write(10'h008, 32'h4);
    bus_write(10'h004, 32'h4);
    pulse(4'h4);
    check("R4 start cancels stop", 64'(ch_run), 64'h6);

    // R7 event during read
    bus_read(10'h01C, 32'h4, "R7 read excludes new event", 4'h2);
    bus_read(10'h01C, 32'h2, "R7 new event kept", '0);

    // R8 mode
    bus_write(10'h240, 32'hFFFF_FFFF);
    bus_read(10'h240, 32'h0000_020F, "R8 mode fields", '0);
    check("R8 prescale ch2", 64'(ch_prescale[8 +: 4]), 64'hF);
    check("R8 invert", 64'(ch_invert), 64'h4);
    bus_write(10'h240, (32'h20F & ~32'hF) | 32'h5);
    bus_read(10'h240, 32'h0000_0205, "R8 rmw keeps invert", '0);
    bus_write(10'h200, 32'h3);
    bus_read(10'h200, 32'h3, "R8 ch0 mode", '0);

    // R9 direct
    bus_write(10'h224, 32'hABCD_1234);
    check("R9 duty ch1", 64'(ch_duty[16 +: 16]), 64'h1234);
    bus_write(10'h22C, 32'h4000);
    check("R9 period ch1", 64'(ch_period[16 +: 16]), 64'h4000);
    bus_read(10'h224, 32'h1234, "R9 duty readback", '0);

    // R10 queued
    bus_write(10'h268, 32'h0777);
    bus_write(10'h270, 32'h0900);
    check("R10 duty not yet", 64'(ch_duty[48 +: 16]), 64'h0);
    check("R10 period not yet", 64'(ch_period[48 +: 16]), 64'h0);
    bus_read(10'h268, 32'h0777, "R10 queued readback", '0);
    pulse(4'h4);
    check("R10 other tick", 64'(ch_duty[48 +: 16]), 64'h0);
    pulse(4'h8);
    check("R10 duty applied", 64'(ch_duty[48 +: 16]), 64'h0777);
    check("R10 period applied", 64'(ch_period[48 +: 16]), 64'h0900);

    // R11 unmapped
    bus_read(10'h010, 32'h0, "R11 global hole", '0);
    bus_read(10'h214, 32'h0, "R11 window hole", '0);
    bus_read(10'h280, 32'h0, "R11 past last channel", '0);
    bus_write(10'h280, 32'hFFFF);
    bus_write(10'h214, 32'hFFFF);
    bus_write(10'h000, 32'hF);
    check("R11 duty untouched", 64'(ch_duty), 64'h0777_0000_1234_0000);
    check("R11 run untouched", 64'(ch_run), 64'h6);
    check("R11 idle rdata", 64'(rdata), 64'h0);

    repeat (3) @(negedge clk);
    check("R11 all reads returned", 64'(exp_q.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule